// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped cache placed between a processor load/store port and a slower main memory that moves one 32-bit word per transfer. Each entry holds a valid flag, an address tag and a block of several words. A load that finds its block resident returns data in the same cycle, with no stall. A load that misses stalls the processor while the block is fetched word by word, and then completes.

Every store goes to main memory through a small posted-write queue, so the processor does not wait for memory on a store unless the queue is full. A store that misses first brings the whole block in and then merges the new word into it. A block therefore never holds words from two different tags. Before any block fetch starts, the queue is emptied, so a fetch always sees the latest stored data.

The processor holds `cpu_req` and its other request signals steady while `cpu_stall` is high. An access completes at the first rising edge where `cpu_stall` is low. Memory transfers follow a request/ready handshake. A transfer completes at a rising edge where both `mem_req` and `mem_ready` are high, and read data is taken from `mem_rdata` in that cycle.

Top module: `wt_cache`

## Requirements
- R1: After reset every entry is invalid. `cpu_stall` and `mem_req` are low, and the first load to any address misses.
- R2: A load that hits, meaning the indexed entry is valid with an equal tag, has `cpu_stall` low in its first cycle and returns the latest stored word of that address.
- R3: A load that misses raises `cpu_stall` and reads the whole block with one memory read per word, in ascending word order starting at the block's base address (word-select and byte bits zero). It then returns the correct data.
- R4: With `cpu_byte` high, a load returns byte `cpu_addr[1:0]` of the word (offset 0 is bits 7:0, offset 3 is bits 31:24), zero-extended to 32 bits. With `cpu_byte` low it returns the full word.
- R5: Every store produces exactly one memory write of the full word to `{cpu_addr[31:2],2'b00}`. Writes reach memory in the order the stores were issued. `cpu_byte` and `cpu_addr[1:0]` do not affect stores.
- R6: A store hit changes only the addressed word of the block. Later loads of the other words of that block still hit and return their earlier values.
- R7: A store miss stalls, fetches the full block as in R3, and then merges the stored word. Later loads of that block hit, returning the new word and the memory values of the other words.
- R8: With the write queue holding `WB_DEPTH` entries, a store stalls until an entry drains. With fewer entries pending, a store hit completes without a stall.
- R9: No block read is issued to memory while any posted store is still pending. A load after an eviction returns the most recently stored value.
- R10: Once `mem_req` is raised, it and `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until a cycle with `mem_ready` high.
- R11: A miss replaces the indexed entry. A later access to the previous tag at that index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_byte | input | 1 | 1 = byte load, 0 = word load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the load completes |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken when mem_ready is high |
| mem_ready | input | 1 | Memory accepts or completes the transfer |

## Verification
A valid flag or tag that is wrong shows up on the first access to that index. The access either fails to stall, or it stalls and issues a block read when it should not. Both are visible in the very cycle the request is presented. A data word that is wrong, or that came from a fill issued before the store queue was empty, appears on `cpu_rdata` at the next load of that word. A queue ordering fault appears at the memory write port when the next posted store drains.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DRAIN = 2'd1,
    CS_FILL  = 2'd2
  } cache_state_e;

  // picks one byte lane of a word, little-endian, zero extended
  function automatic logic [31:0] lane_pick(input logic [31:0] w, input logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0:    b = w[7:0];
      2'd1:    b = w[15:8];
      2'd2:    b = w[23:16];
      default: b = w[31:24];
    endcase
    return {24'd0, b};
  endfunction

endpackage

// File: rtl/wt_cache_array.sv
module wt_cache_array #(
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [OFS_W-1:0] rd_wsel,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [31:0]      rd_word,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFS_W-1:0] wr_wsel,
  input  logic [31:0]      wr_word,
  input  logic             tag_en,
  input  logic [IDX_W-1:0] tag_idx,
  input  logic [TAG_W-1:0] tag_val
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SLOTS   = ENTRIES << OFS_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [31:0]        data_q [SLOTS];

  always_comb begin
    valid_d = valid_q;
    if (tag_en) valid_d[tag_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_en) tag_q[tag_idx] <= tag_val;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{wr_idx, wr_wsel}] <= wr_word;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_word  = data_q[{rd_idx, rd_wsel}];

endmodule

// File: rtl/wt_cache_wbuf.sv
module wt_cache_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 62
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rptr_q];

  always_comb begin
    wptr_d = do_push ? bump(wptr_q) : wptr_q;
    rptr_d = do_pop  ? bump(rptr_q) : rptr_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wptr_q] <= push_data;
  end

endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             hit,
  input  logic             wb_full,
  input  logic             wb_empty,
  input  logic             mem_ready,
  output logic             cpu_stall,
  output logic             store_ok,
  output logic             fill_active,
  output logic             fill_we,
  output logic             fill_last,
  output logic [OFS_W-1:0] fill_wsel
);
  cache_state_e     state_q, state_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cpu_stall = 1'b0;
    store_ok  = 1'b0;
    fill_we   = 1'b0;
    fill_last = 1'b0;
    case (state_q)
      CS_IDLE: begin
        if (cpu_req) begin
          if (!hit) begin
            cpu_stall = 1'b1;
            state_d   = CS_DRAIN;
          end else if (cpu_we) begin
            if (wb_full) cpu_stall = 1'b1;
            else         store_ok  = 1'b1;
          end
        end
      end
      CS_DRAIN: begin
        cpu_stall = 1'b1;
        if (wb_empty) begin
          state_d = CS_FILL;
          cnt_d   = '0;
        end
      end
      CS_FILL: begin
        cpu_stall = 1'b1;
        if (mem_ready) begin
          fill_we = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == '1) begin
            fill_last = 1'b1;
            state_d   = CS_IDLE;
          end
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fill_active = (state_q == CS_FILL);
  assign fill_wsel   = cnt_q;

endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int OFS_W    = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_byte,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  localparam int TAG_W = 32 - IDX_W - OFS_W - 2;
  localparam int WB_W  = 30 + 32;

  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFS_W-1:0] a_wsel;
  logic [1:0]       a_boff;

  assign a_tag  = cpu_addr[31 -: TAG_W];
  assign a_idx  = cpu_addr[OFS_W+2 +: IDX_W];
  assign a_wsel = cpu_addr[2 +: OFS_W];
  assign a_boff = cpu_addr[1:0];

  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [31:0]      rd_word;
  logic             hit;
  logic             store_ok, fill_active, fill_we, fill_last;
  logic [OFS_W-1:0] fill_wsel;
  logic             wb_empty, wb_full, wb_pop;
  logic [WB_W-1:0]  wb_head;
  logic             arr_we;
  logic [OFS_W-1:0] arr_wsel;
  logic [31:0]      arr_word;

  assign hit = rd_valid && (rd_tag == a_tag);

  wt_cache_ctrl #(.OFS_W(OFS_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .hit         (hit),
    .wb_full     (wb_full),
    .wb_empty    (wb_empty),
    .mem_ready   (mem_ready),
    .cpu_stall   (cpu_stall),
    .store_ok    (store_ok),
    .fill_active (fill_active),
    .fill_we     (fill_we),
    .fill_last   (fill_last),
    .fill_wsel   (fill_wsel)
  );

  // one data write port shared by store hits and fill words
  assign arr_we   = store_ok || fill_we;
  assign arr_wsel = fill_active ? fill_wsel : a_wsel;
  assign arr_word = fill_active ? mem_rdata : cpu_wdata;

  wt_cache_array #(.IDX_W(IDX_W), .OFS_W(OFS_W), .TAG_W(TAG_W)) i_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (a_idx),
    .rd_wsel  (a_wsel),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_word  (rd_word),
    .wr_en    (arr_we),
    .wr_idx   (a_idx),
    .wr_wsel  (arr_wsel),
    .wr_word  (arr_word),
    .tag_en   (fill_last),
    .tag_idx  (a_idx),
    .tag_val  (a_tag)
  );

  assign wb_pop = !fill_active && mem_ready;

  wt_cache_wbuf #(.DEPTH(WB_DEPTH), .W(WB_W)) i_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store_ok),
    .push_data ({cpu_addr[31:2], cpu_wdata}),
    .pop       (wb_pop),
    .head      (wb_head),
    .empty     (wb_empty),
    .full      (wb_full)
  );

  assign mem_req   = fill_active || !wb_empty;
  assign mem_we    = !fill_active;
  assign mem_addr  = fill_active ? {a_tag, a_idx, fill_wsel, 2'b00} : {wb_head[WB_W-1:32], 2'b00};
  assign mem_wdata = fill_active ? 32'd0 : wb_head[31:0];

  assign cpu_rdata = cpu_byte ? lane_pick(rd_word, a_boff) : rd_word;

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int OFS_W = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_stall,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        wb_empty,
  input logic        wb_full
);
  logic rd_xfer;
  assign rd_xfer = mem_req && !mem_we;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R9
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer |-> wb_empty);

  // R3
  fill_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer |-> cpu_stall);

  // R3
  fill_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer && !$past(rd_xfer) |-> mem_addr[OFS_W+1:0] == '0);

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer && mem_ready && (mem_addr[OFS_W+1:2] != '1) |=>
      rd_xfer && (mem_addr == $past(mem_addr) + 32'd4));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && wb_full |-> cpu_stall);

endmodule

bind wt_cache wt_cache_chk #(.OFS_W(OFS_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_stall (cpu_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wb_empty  (wb_empty),
  .wb_full   (wb_full)
);

// File: tb/test_wt_cache.sv
module test_wt_cache;
  localparam int IDX_W = 4;
  localparam int OFS_W = 2;
  localparam int WB_DEPTH = 4;
  localparam int WORDS = 1 << OFS_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int fails = 0;
  logic mem_block = 1'b0;

  logic [31:0] mm   [logic [31:0]];
  logic [31:0] refm [logic [31:0]];
  logic [63:0] wq[$];
  logic [31:0] rd_log[$];
  logic              rv [ENTRIES];
  logic [23:0]       rt [ENTRIES];

  always #2 clk = ~clk;

  wt_cache #(.IDX_W(IDX_W), .OFS_W(OFS_W), .WB_DEPTH(WB_DEPTH)) i_wt_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_byte(cpu_byte),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic void chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endfunction

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] mm_rd(input logic [31:0] a);
    return mm.exists(a) ? mm[a] : dflt(a);
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : dflt(a);
  endfunction

  // memory model, all action at the falling edge
  logic        prev_wait = 1'b0;
  logic        prev_we = 1'b0;
  logic [31:0] prev_addr = '0, prev_wd = '0;
  always @(negedge clk) begin
    logic go;
    if (!rst_n) begin
      mem_ready = 1'b0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait)
        chk(mem_req && mem_we == prev_we && mem_addr == prev_addr && mem_wdata == prev_wd,
            "R10 request held", mem_addr, prev_addr);
      go = mem_req && !mem_block && ($urandom_range(3) != 0);
      mem_ready = go;
      if (go) begin
        if (mem_we) begin
          if (wq.size() == 0) chk(1'b0, "R5 unexpected write", mem_addr, 32'hFFFFFFFF);
          else begin
            logic [63:0] e;
            e = wq.pop_front();
            chk(mem_addr == e[63:32], "R5 write address", mem_addr, e[63:32]);
            chk(mem_wdata == e[31:0], "R5 write data", mem_wdata, e[31:0]);
          end
          mm[mem_addr] = mem_wdata;
        end else begin
          chk(wq.size() == 0, "R9 fill read with stores pending", wq.size(), 0);
          rd_log.push_back(mem_addr);
          mem_rdata = mm_rd(mem_addr);
        end
      end
      prev_wait = mem_req && !go;
      prev_we = mem_we; prev_addr = mem_addr; prev_wd = mem_wdata;
    end
  end

  task automatic do_acc(input logic we, input logic byt, input logic [31:0] addr,
                        input logic [31:0] wd, input string rq, output logic fs);
    int idx;
    logic [23:0] tg;
    logic exp_hit;
    logic [31:0] al, w, e;
    idx = int'(addr[7:4]);
    tg = addr[31:8];
    al = {addr[31:2], 2'b00};
    exp_hit = rv[idx] && rt[idx] == tg;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_byte = byt; cpu_addr = addr; cpu_wdata = wd;
    rd_log.delete();
    #1;
    fs = cpu_stall;
    if (cpu_stall && mem_block) mem_block = 1'b0;
    if (!we) chk(fs == !exp_hit, exp_hit ? {rq, " R2 hit no stall"} : {rq, " R3 miss stalls"},
                 32'(fs), 32'(!exp_hit));
    else if (!exp_hit) chk(fs == 1'b1, {rq, " R7 store miss stalls"}, 32'(fs), 1);
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    if (!exp_hit) begin
      chk(rd_log.size() == WORDS, {rq, " R3 fill length"}, rd_log.size(), WORDS);
      for (int k = 0; k < WORDS && k < rd_log.size(); k++)
        chk(rd_log[k] == {addr[31:4], 2'(k), 2'b00}, {rq, " R3 fill order"}, rd_log[k],
            {addr[31:4], 2'(k), 2'b00});
    end
    if (!we) begin
      w = ref_rd(al);
      e = byt ? ((w >> (8 * addr[1:0])) & 32'hFF) : w;
      chk(cpu_rdata == e, byt ? {rq, " R4 byte load"} : {rq, " R2 load data"}, cpu_rdata, e);
    end else begin
      refm[al] = wd;
      wq.push_back({al, wd});
    end
    rv[idx] = 1'b1;
    rt[idx] = tg;
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [23:0] tg, input int idx, input int w, input int b);
    return {tg, 4'(idx), 2'(w), 2'(b)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic fs;
    for (int i = 0; i < ENTRIES; i++) begin rv[i] = 1'b0; rt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cpu_stall, "R1 stall low after reset", 32'(cpu_stall), 0);
    chk(!mem_req, "R1 no memory request after reset", 32'(mem_req), 0);

    // R1: first load must miss
    do_acc(0, 0, mk(24'h000000, 0, 0, 0), 0, "R1", fs);
    chk(fs, "R1 first access misses", 32'(fs), 1);

    // R4: every byte lane of a resident word
    for (int b = 0; b < 4; b++) do_acc(0, 1, mk(24'h000000, 0, 1, b), 0, "R4", fs);

    // R6: store hit leaves other words alone
    do_acc(1, 0, mk(24'h000000, 0, 2, 0), 32'hCAFE0002, "R6", fs);
    for (int w = 0; w < 4; w++) do_acc(0, 0, mk(24'h000000, 0, w, 0), 0, "R6", fs);

    // R7: store miss fetches block then merges
    do_acc(1, 0, mk(24'h000011, 3, 1, 0), 32'h77770001, "R7", fs);
    for (int w = 0; w < 4; w++) do_acc(0, 0, mk(24'h000011, 3, w, 0), 0, "R7", fs);

    // R11 and R9: store, evict by conflict, reload
    do_acc(1, 0, mk(24'h000011, 3, 0, 0), 32'h99990000, "R9", fs);
    do_acc(0, 0, mk(24'h000022, 3, 0, 0), 0, "R11", fs);
    do_acc(0, 0, mk(24'h000011, 3, 0, 0), 0, "R11", fs);
    chk(fs, "R11 evicted tag misses", 32'(fs), 1);
    do_acc(0, 0, mk(24'h000011, 3, 0, 0), 0, "R9", fs);

    // R5: store ignores byte flag and byte offset
    do_acc(1, 1, mk(24'h000011, 3, 2, 3), 32'hABCD1234, "R5", fs);
    do_acc(0, 0, mk(24'h000011, 3, 2, 0), 0, "R5", fs);

    // R8: queue fill with memory held off
    do_acc(0, 0, mk(24'h000200, 5, 0, 0), 0, "R8", fs);
    mem_block = 1'b1;
    for (int i = 0; i < WB_DEPTH; i++) begin
      do_acc(1, 0, mk(24'h000200, 5, i % 4, 0), 32'h80000000 + 32'(i), "R8", fs);
      chk(!fs, "R8 store accepted while queue has room", 32'(fs), 0);
    end
    do_acc(1, 0, mk(24'h000200, 5, 3, 0), 32'h8000FFFF, "R8", fs);
    chk(fs, "R8 store stalls on full queue", 32'(fs), 1);
    mem_block = 1'b0;

    // random mix over few tags and indexes
    for (int n = 0; n < 400; n++) begin
      logic [23:0] tg;
      int idx, w, b;
      logic st, by;
      tg = 24'h000300 + 24'($urandom_range(2));
      idx = $urandom_range(3);
      w = $urandom_range(3);
      st = ($urandom_range(2) == 0);
      by = st ? 1'b0 : 1'($urandom_range(1));
      b = by ? $urandom_range(3) : 0;
      do_acc(st, by, mk(tg, idx, w, b), $urandom(), "RND", fs);
    end

    // let the queue drain so every store is seen at memory
    repeat (60) @(posedge clk);
    chk(wq.size() == 0, "R5 all stores reached memory", wq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
  end

endmodule